// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block sits beside a UART receive FIFO and tells the interrupt encoder when received data has been left unread for too long. While the FIFO is enabled and holds at least one character, the block counts baud ticks. When four whole character times pass with nothing happening, it raises a timeout flag. The length of a character time comes from the frame length input, given in bit times.

There are three events that clear the flag and restart the count: a read from the receive FIFO, a reset of the FIFO, or a new start bit seen on the line. The count also restarts when the FIFO is empty or FIFO operation is switched off. Once the flag is set it stays set, and further ticks do nothing, until one of these events occurs.

Top module: `rx_char_timeout`

## Requirements
- R1: After a synchronous reset, `timeout_flag` is 0.
- R2: While `fifo_mode_en` is 0, `timeout_flag` is 0 from the next clock on, and the idle count is held at zero.
- R3: While `fifo_level` is 0, `timeout_flag` is 0 from the next clock on, and the idle count is held at zero.
- R4: When the FIFO is enabled and non-empty with no clear event, each clock with `baud_tick` high adds one to the idle count. `timeout_flag` rises on the clock edge that follows the tick bringing the count to 4*L, where L is `char_bits` (a value of 0 counts as 1). Clocks without `baud_tick` add nothing.
- R5: A clock with `fifo_rd` high clears `timeout_flag` at that edge and restarts the idle count from zero.
- R6: A clock with `fifo_clr` high clears `timeout_flag` at that edge and restarts the idle count from zero.
- R7: A clock with `start_det` high clears `timeout_flag` at that edge and restarts the idle count from zero.
- R8: Once set, `timeout_flag` stays at 1 through any number of further baud ticks until a clear event (R5 to R7) occurs or the block is disarmed (R2, R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| char_bits | input | LEN_W | Bit times per character (start, data, parity, stop) |
| fifo_level | input | CNT_W | Characters held in the receive FIFO |
| fifo_rd | input | 1 | Receive FIFO read strobe |
| fifo_clr | input | 1 | Receive FIFO reset strobe |
| start_det | input | 1 | New start bit detected strobe |
| fifo_mode_en | input | 1 | FIFO operation enabled |
| timeout_flag | output | 1 | Character timeout indication |

## Verification
The timeout is tested with several frame lengths: 7, 10, 1 and 0, the last of which must behave like 1. A count that stops one tick short shows that the threshold is exactly four characters, and gaps between ticks show that only baud ticks advance the count. Each of the three clear strobes is applied both while the flag is set and part way through a count, so a clear that drops the flag but leaves a stale count behind is exposed. Emptying the FIFO and switching off FIFO mode are each tried in the middle of a count.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;

    localparam int unsigned TMO_CHARS = 4;
    localparam int unsigned CHAR_CW   = $clog2(TMO_CHARS);

    typedef struct packed {
        logic armed;
        logic restart;
    } tmo_ctrl_t;

    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_FIRED = 1'b1
    } tmo_state_e;

    function automatic logic [15:0] eff_len(input logic [15:0] raw);
        return (raw == 16'd0) ? 16'd1 : raw;
    endfunction

endpackage

// File: rtl/rx_tmo_ctrl.sv
module rx_tmo_ctrl
    import rx_tmo_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             fifo_rd,
    input  logic             fifo_clr,
    input  logic             start_det,
    input  logic             fifo_mode_en,
    input  logic [CNT_W-1:0] fifo_level,
    output tmo_ctrl_t        ctrl
);
    always_comb begin
        ctrl.armed   = fifo_mode_en && (fifo_level != '0);
        ctrl.restart = fifo_rd || fifo_clr || start_det || !ctrl.armed;
    end
endmodule

// File: rtl/rx_tmo_bit_timer.sv
module rx_tmo_bit_timer
    import rx_tmo_pkg::*;
#(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             hold,
    input  logic             baud_tick,
    input  logic [LEN_W-1:0] char_bits,
    output logic             char_done
);
    logic [LEN_W-1:0] bit_cnt;
    logic [LEN_W-1:0] last_bit;
    logic [15:0]      len16;

    always_comb begin
        len16    = eff_len(16'(char_bits));
        last_bit = LEN_W'(len16 - 16'd1);
        char_done = baud_tick && !hold && !restart && (bit_cnt == last_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bit_cnt <= '0;
        end else if (baud_tick && !hold) begin
            if (bit_cnt == last_bit) bit_cnt <= '0;
            else                     bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rx_tmo_char_counter.sv
module rx_tmo_char_counter
    import rx_tmo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic char_done,
    output logic fired
);
    logic [CHAR_CW-1:0] char_cnt;
    tmo_state_e         state;

    localparam logic [CHAR_CW-1:0] LAST_CHAR = CHAR_CW'(TMO_CHARS - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            char_cnt <= '0;
            state    <= ST_COUNT;
        end else if (char_done && state == ST_COUNT) begin
            if (char_cnt == LAST_CHAR) begin
                state <= ST_FIRED;
            end else begin
                char_cnt <= char_cnt + 1'b1;
            end
        end
    end

    assign fired = (state == ST_FIRED);
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
    import rx_tmo_pkg::*;
#(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick,
    input  logic [LEN_W-1:0] char_bits,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic             fifo_rd,
    input  logic             fifo_clr,
    input  logic             start_det,
    input  logic             fifo_mode_en,
    output logic             timeout_flag
);
    tmo_ctrl_t ctrl;
    logic      char_done;
    logic      fired;

    rx_tmo_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .fifo_rd      (fifo_rd),
        .fifo_clr     (fifo_clr),
        .start_det    (start_det),
        .fifo_mode_en (fifo_mode_en),
        .fifo_level   (fifo_level),
        .ctrl         (ctrl)
    );

    rx_tmo_bit_timer #(.LEN_W(LEN_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .restart   (ctrl.restart),
        .hold      (fired),
        .baud_tick (baud_tick),
        .char_bits (char_bits),
        .char_done (char_done)
    );

    rx_tmo_char_counter u_chars (
        .clk       (clk),
        .rst       (rst),
        .restart   (ctrl.restart),
        .char_done (char_done),
        .fired     (fired)
    );

    assign timeout_flag = fired;
endmodule

// File: rtl/rx_char_timeout_chk.sv
module rx_char_timeout_chk #(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             baud_tick,
    input logic [LEN_W-1:0] char_bits,
    input logic [CNT_W-1:0] fifo_level,
    input logic             fifo_rd,
    input logic             fifo_clr,
    input logic             start_det,
    input logic             fifo_mode_en,
    input logic             timeout_flag
);
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !timeout_flag);

    a_r2_mode_off: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode_en |=> !timeout_flag);

    a_r3_empty_fifo: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |=> !timeout_flag);

    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        !timeout_flag && !baud_tick |=> !timeout_flag);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !timeout_flag);

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> !timeout_flag);

    a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !timeout_flag);

    a_r8_holds: assert property (@(posedge clk) disable iff (rst)
        timeout_flag && !fifo_rd && !fifo_clr && !start_det && fifo_mode_en
        && (fifo_level != '0) |=> timeout_flag);
endmodule

bind rx_char_timeout rx_char_timeout_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rx_char_timeout.sv
`timescale 1ns/1ps
module tb_rx_char_timeout;
    localparam int LEN_W = 4;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             baud_tick = 1'b0;
    logic [LEN_W-1:0] char_bits = 4'd10;
    logic [CNT_W-1:0] fifo_level = '0;
    logic             fifo_rd = 1'b0;
    logic             fifo_clr = 1'b0;
    logic             start_det = 1'b0;
    logic             fifo_mode_en = 1'b0;
    logic             timeout_flag;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    rx_char_timeout #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (.*);

    always #2.5 clk = ~clk;

    // Behavioural reference: idle tick count against four frames.
    int idle_ticks = 0;
    bit exp_flag = 1'b0;
    always @(posedge clk) begin
        int frame;
        frame = (char_bits == 0) ? 1 : int'(char_bits);
        if (rst || fifo_rd || fifo_clr || start_det || !fifo_mode_en || fifo_level == 0) begin
            idle_ticks = 0;
            exp_flag   = 1'b0;
        end else if (baud_tick && !exp_flag) begin
            idle_ticks++;
            if (idle_ticks == 4 * frame) exp_flag = 1'b1;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, 1 ns after the edge.
    always begin
        @(posedge clk);
        #1;
        if (!rst) check(timeout_flag == exp_flag, phase, timeout_flag, exp_flag);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic arm(input int len);
        @(negedge clk);
        char_bits = LEN_W'(len);
        fifo_level = 6'd3;
        fifo_mode_en = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        phase = "R1";
        check(timeout_flag == 1'b0, "R1", timeout_flag, 0);
        rst = 1'b0;
        idle(2);
        check(timeout_flag == 1'b0, "R1", timeout_flag, 0);

        // R4: exact threshold, frame 10, ticks with gaps
        phase = "R4";
        arm(10);
        ticks(39, 2);
        idle(3);
        check(timeout_flag == 1'b0, "R4", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R4", timeout_flag, 1);

        // R8: flag holds through more ticks
        phase = "R8";
        ticks(25, 1);
        check(timeout_flag == 1'b1, "R8", timeout_flag, 1);

        // R5: read clears, then count restarts from zero
        phase = "R5";
        pulse(fifo_rd);
        check(timeout_flag == 1'b0, "R5", timeout_flag, 0);
        ticks(20, 0);
        pulse(fifo_rd);
        ticks(39, 0);
        check(timeout_flag == 1'b0, "R5", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R5", timeout_flag, 1);

        // R6: FIFO reset strobe
        phase = "R6";
        pulse(fifo_clr);
        check(timeout_flag == 1'b0, "R6", timeout_flag, 0);
        ticks(33, 1);
        pulse(fifo_clr);
        ticks(39, 0);
        check(timeout_flag == 1'b0, "R6", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R6", timeout_flag, 1);

        // R7: start bit detection, frame 7
        phase = "R7";
        arm(7);
        pulse(start_det);
        check(timeout_flag == 1'b0, "R7", timeout_flag, 0);
        ticks(15, 0);
        pulse(start_det);
        ticks(27, 0);
        check(timeout_flag == 1'b0, "R7", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R7", timeout_flag, 1);

        // R3: empty FIFO disarms and restarts
        phase = "R3";
        @(negedge clk); fifo_level = '0;
        ticks(40, 0);
        check(timeout_flag == 1'b0, "R3", timeout_flag, 0);
        @(negedge clk); fifo_level = 6'd1;
        ticks(20, 0);
        @(negedge clk); fifo_level = '0;
        @(negedge clk); fifo_level = 6'd1;
        ticks(27, 0);
        check(timeout_flag == 1'b0, "R3", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R3", timeout_flag, 1);

        // R2: FIFO mode off
        phase = "R2";
        @(negedge clk); fifo_mode_en = 1'b0;
        @(negedge clk);
        check(timeout_flag == 1'b0, "R2", timeout_flag, 0);
        ticks(40, 0);
        check(timeout_flag == 1'b0, "R2", timeout_flag, 0);
        @(negedge clk); fifo_mode_en = 1'b1;
        ticks(10, 0);
        @(negedge clk); fifo_mode_en = 1'b0;
        @(negedge clk); fifo_mode_en = 1'b1;
        ticks(27, 0);
        check(timeout_flag == 1'b0, "R2", timeout_flag, 0);

        // R4: frame 1 and frame 0 both mean four ticks
        phase = "R4";
        pulse(fifo_rd);
        arm(1);
        ticks(3, 0);
        check(timeout_flag == 1'b0, "R4", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R4", timeout_flag, 1);
        pulse(fifo_rd);
        arm(0);
        ticks(3, 3);
        check(timeout_flag == 1'b0, "R4", timeout_flag, 0);
        ticks(1, 0);
        check(timeout_flag == 1'b1, "R4", timeout_flag, 1);

        // R1: reset while flag set
        phase = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(timeout_flag == 1'b0, "R1", timeout_flag, 0);
        rst = 1'b0;
        idle(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule